// File: doc/BRIEF.md
# Capacity Trust Charge Counter

This block keeps track of how far the gauge's learned full capacity can be trusted. Every qualified charge event that arrives before a new capacity has been learned is counted in an 8-bit saturating counter. When that counter reaches a set level, a capacity-inaccurate flag is raised. Host logic reads the count as a read-only byte at register offset 09h. The address decode sits outside this block.

The counter must not keep climbing while a trickle charger tops up a nearly full pack. To prevent that, the present available charge is compared every cycle against 94% of the learned capacity. At or above that level, only the first charge event counts. Later charge events are ignored until the available charge drops back under the threshold.

The block also decides when a new capacity may be learned. It arms when the available charge equals the learned capacity. It disarms on any charge event. When the empty indication arrives while the block is armed, it emits a one-cycle learn strobe, provided the temperature is not negative and the self-discharge count is small. The same strobe clears the counter and the flag.

Top module: `cap_trust_tracker`

## Requirements
- R1: During and just after reset, the count is 0, the inaccurate flag is 0 and the learn strobe is 0 until the block has armed again.
- R2: A charge strobe in a cycle where 100·available < 94·capacity (unsigned) adds one to the count at the next clock edge.
- R3: At or above the threshold, only the first charge strobe counts. Later strobes leave the count unchanged until a cycle with available charge below the threshold has been seen.
- R4: The count stops at 255 and never wraps.
- R5: The inaccurate flag rises at the same edge on which the count becomes 64. It stays high until a learn strobe.
- R6: Tracking arms in any cycle where available equals capacity and the empty input is low. While armed, the learn strobe is high in the same cycle as the empty input, provided temperature-negative is 0 and the self-discharge count is below 4096.
- R7: A charge strobe in a cycle where available differs from capacity disarms tracking, so a later empty input gives no learn strobe.
- R8: A high empty input always disarms tracking. With temperature-negative at 1, or a self-discharge count of 4096 or more, no strobe is given, and a second empty cycle gives none either.
- R9: A learn strobe clears the count and the inaccurate flag at the next edge, even when a charge strobe comes in the same cycle.
- R10: Available charge exactly equal to 94% of capacity counts as at or above the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chg_valid_i | input | 1 | One-cycle qualified charge event |
| avail_i | input | 16 | Present nominal available charge |
| learned_i | input | 16 | Learned maximum capacity |
| empty_i | input | 1 | Empty-voltage indication |
| temp_neg_i | input | 1 | 1 when temperature is below 0 °C |
| selfdis_i | input | 16 | Self-discharge counter value |
| count_o | output | 8 | Charge count since last learn (register 09h) |
| inacc_o | output | 1 | Capacity-inaccurate flag |
| learn_ok_o | output | 1 | Learn-qualify strobe |

## Verification
A stale or wrong suppress latch shows up on the very next charge strobe as a count that is one too high or one too low. From then on the difference stays visible on count_o until a learn strobe. A wrong arming state can go unseen for many cycles and only appears when empty_i rises, as a missing or extra learn_ok_o pulse in that same cycle. That is why the bench builds long sequences of full, charge and empty cycles. It compares the count, the flag and the strobe against a behavioural model in every cycle, so any difference is caught at the first edge where it becomes visible.

// File: rtl/ct_pkg.sv
package ct_pkg;
    typedef enum logic {
        LRN_IDLE  = 1'b0,
        LRN_ARMED = 1'b1
    } lrn_state_e;

    localparam int unsigned CT_DATA_W = 16;
    localparam int unsigned CT_CNT_W  = 8;
endpackage

// File: rtl/ct_thresh_cmp.sv
module ct_thresh_cmp #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned PCT_NUM = 94,
    parameter int unsigned PCT_DEN = 100
) (
    input  logic [DATA_W-1:0] avail_i,
    input  logic [DATA_W-1:0] learned_i,
    output logic              below_o
);
    localparam int unsigned PROD_W = DATA_W + $clog2(PCT_DEN + 1) + 1;

    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;

    generate
        if (PCT_NUM >= PCT_DEN) begin : g_full
            assign lhs = PROD_W'(avail_i);
            assign rhs = PROD_W'(learned_i);
        end else begin : g_scaled
            assign lhs = PROD_W'(avail_i) * PROD_W'(PCT_DEN);
            assign rhs = PROD_W'(learned_i) * PROD_W'(PCT_NUM);
        end
    endgenerate

    assign below_o = lhs < rhs;
endmodule

// File: rtl/ct_learn_qual.sv
module ct_learn_qual
    import ct_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned SD_W     = 16,
    parameter int unsigned SD_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chg_i,
    input  logic [DATA_W-1:0] avail_i,
    input  logic [DATA_W-1:0] learned_i,
    input  logic              empty_i,
    input  logic              temp_neg_i,
    input  logic [SD_W-1:0]   selfdis_i,
    output logic              learn_o
);
    typedef struct packed {
        lrn_state_e st;
    } lrn_t;

    lrn_t cur_q, nxt_d;
    logic full;
    logic env_ok;

    assign full   = (avail_i == learned_i);
    assign env_ok = !temp_neg_i && (selfdis_i < SD_W'(SD_LIMIT));

    always_comb begin
        nxt_d   = cur_q;
        learn_o = (cur_q.st == LRN_ARMED) && empty_i && env_ok;
        if (empty_i)
            nxt_d.st = LRN_IDLE;
        else if (full)
            nxt_d.st = LRN_ARMED;
        else if (chg_i)
            nxt_d.st = LRN_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '{st: LRN_IDLE};
        else
            cur_q <= nxt_d;
    end

    // R6
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        learn_o |=> !learn_o);

    // R7
    chg_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_i && !full && !empty_i) |=> (cur_q.st == LRN_IDLE));

    // R8
    empty_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_i |=> !learn_o || !empty_i);
endmodule

// File: rtl/ct_charge_count.sv
module ct_charge_count #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned CI_LEVEL = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chg_i,
    input  logic             below_i,
    input  logic             learn_i,
    output logic [CNT_W-1:0] count_o,
    output logic             inacc_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CI_PRE  = CNT_W'(CI_LEVEL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             inacc;
        logic             supp;
    } cnt_t;

    cnt_t cur_q, nxt_d;
    logic inc;

    always_comb begin
        nxt_d = cur_q;
        inc   = chg_i && (below_i || !cur_q.supp);
        if (learn_i) begin
            nxt_d.count = '0;
            nxt_d.inacc = 1'b0;
            nxt_d.supp  = 1'b0;
        end else begin
            if (inc && cur_q.count != CNT_MAX)
                nxt_d.count = cur_q.count + 1'b1;
            if (inc && cur_q.count == CI_PRE)
                nxt_d.inacc = 1'b1;
            if (below_i)
                nxt_d.supp = 1'b0;
            else if (chg_i)
                nxt_d.supp = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign count_o = cur_q.count;
    assign inacc_o = cur_q.inacc;

    // R2
    below_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_i && below_i && !learn_i && count_o != CNT_MAX)
        |=> count_o == $past(count_o) + 1'b1);

    // R3
    supp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_i && !below_i && cur_q.supp && !learn_i) |=> $stable(count_o));

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == CNT_MAX && !learn_i) |=> count_o == CNT_MAX);

    // R5
    ci_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inacc_o == (count_o >= CNT_W'(CI_LEVEL)));

    // R9
    learn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        learn_i |=> (count_o == '0) && !inacc_o);
endmodule

// File: rtl/cap_trust_tracker.sv
module cap_trust_tracker
    import ct_pkg::*;
#(
    parameter int unsigned DATA_W   = CT_DATA_W,
    parameter int unsigned CNT_W    = CT_CNT_W,
    parameter int unsigned SD_W     = 16,
    parameter int unsigned SD_LIMIT = 4096,
    parameter int unsigned CI_LEVEL = 64,
    parameter int unsigned PCT_NUM  = 94,
    parameter int unsigned PCT_DEN  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chg_valid_i,
    input  logic [DATA_W-1:0] avail_i,
    input  logic [DATA_W-1:0] learned_i,
    input  logic              empty_i,
    input  logic              temp_neg_i,
    input  logic [SD_W-1:0]   selfdis_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              inacc_o,
    output logic              learn_ok_o
);
    logic below;
    logic learn;

    ct_thresh_cmp #(
        .DATA_W (DATA_W),
        .PCT_NUM(PCT_NUM),
        .PCT_DEN(PCT_DEN)
    ) u_cmp (
        .avail_i  (avail_i),
        .learned_i(learned_i),
        .below_o  (below)
    );

    ct_learn_qual #(
        .DATA_W  (DATA_W),
        .SD_W    (SD_W),
        .SD_LIMIT(SD_LIMIT)
    ) u_lrn (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_i     (chg_valid_i),
        .avail_i   (avail_i),
        .learned_i (learned_i),
        .empty_i   (empty_i),
        .temp_neg_i(temp_neg_i),
        .selfdis_i (selfdis_i),
        .learn_o   (learn)
    );

    ct_charge_count #(
        .CNT_W   (CNT_W),
        .CI_LEVEL(CI_LEVEL)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .chg_i  (chg_valid_i),
        .below_i(below),
        .learn_i(learn),
        .count_o(count_o),
        .inacc_o(inacc_o)
    );

    assign learn_ok_o = learn;
endmodule

// File: tb/cap_trust_tracker_test.sv
`timescale 1ns/1ps
module cap_trust_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chg = 1'b0;
    logic [15:0] avail = 16'd0;
    logic [15:0] learned = 16'd1000;
    logic        empty = 1'b0;
    logic        tneg = 1'b0;
    logic [15:0] sd = 16'd0;
    logic [7:0]  count_o;
    logic        inacc_o;
    logic        learn_ok_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_req = "R1";

    int m_cnt = 0;
    int m_ci = 0;
    int m_supp = 0;
    int m_armed = 0;

    always #2.5 clk = ~clk;

    cap_trust_tracker uut (
        .clk(clk), .rst_n(rst_n), .chg_valid_i(chg), .avail_i(avail),
        .learned_i(learned), .empty_i(empty), .temp_neg_i(tneg),
        .selfdis_i(sd), .count_o(count_o), .inacc_o(inacc_o),
        .learn_ok_o(learn_ok_o)
    );

    function automatic int m_learn();
        return (m_armed != 0 && empty && !tneg && sd < 16'd4096) ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int lrn;
        int below;
        int inc;
        lrn   = m_learn();
        below = (int'(avail) * 100 < int'(learned) * 94) ? 1 : 0;
        if (lrn != 0) begin
            m_cnt = 0; m_ci = 0; m_supp = 0;
        end else begin
            inc = (chg && (below != 0 || m_supp == 0)) ? 1 : 0;
            if (inc != 0 && m_cnt < 255) m_cnt++;
            if (m_cnt >= 64) m_ci = 1;
            if (below != 0) m_supp = 0;
            else if (chg) m_supp = 1;
        end
        if (empty) m_armed = 0;
        else if (avail == learned) m_armed = 1;
        else if (chg) m_armed = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        #0.5;
        check(cur_req, "count", int'(count_o), m_cnt);
        check(cur_req, "inacc", int'(inacc_o), m_ci);
        check(cur_req, "learn_ok", int'(learn_ok_o), m_learn());
        @(posedge clk);
        #1;
        model_step();
    endtask

    task automatic drv(input bit c, input int a, input bit e, input bit t, input int s);
        chg = c; avail = 16'(a); empty = e; tneg = t; sd = 16'(s);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "count in reset", int'(count_o), 0);
        check("R1", "inacc in reset", int'(inacc_o), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        cur_req = "R1";
        drv(0, 500, 1, 0, 0); cyc();
        drv(0, 500, 0, 0, 0); cyc();

        // R2: counting below threshold
        cur_req = "R2";
        for (int i = 0; i < 5; i++) begin
            drv(1, 500, 0, 0, 0); cyc();
            drv(0, 500, 0, 0, 0); cyc();
        end
        drv(1, 100, 0, 0, 0); cyc();
        drv(1, 0, 0, 0, 0); cyc();
        drv(0, 0, 0, 0, 0); cyc();
        check("R2", "count after 7", int'(count_o), 7);

        // R10 / R3: exactly at 94% is not below
        cur_req = "R10";
        for (int i = 0; i < 3; i++) begin
            drv(1, 940, 0, 0, 0); cyc();
        end
        drv(0, 940, 0, 0, 0); cyc();
        check("R10", "count at threshold", int'(count_o), 8);
        cur_req = "R3";
        drv(1, 939, 0, 0, 0); cyc();
        drv(1, 990, 0, 0, 0); cyc();
        drv(1, 990, 0, 0, 0); cyc();
        drv(1, 995, 0, 0, 0); cyc();
        drv(0, 930, 0, 0, 0); cyc();
        drv(1, 990, 0, 0, 0); cyc();
        drv(0, 990, 0, 0, 0); cyc();
        check("R3", "count after relatch", int'(count_o), 11);

        // R5: flag at 64
        cur_req = "R5";
        while (m_cnt < 70) begin
            drv(1, 500, 0, 0, 0); cyc();
        end
        drv(0, 500, 0, 0, 0); cyc();
        check("R5", "inacc above 64", int'(inacc_o), 1);

        // R4: saturation
        cur_req = "R4";
        while (m_cnt < 255) begin
            drv(1, 200, 0, 0, 0); cyc();
        end
        for (int i = 0; i < 10; i++) begin
            drv(1, 200, 0, 0, 0); cyc();
        end
        drv(0, 200, 0, 0, 0); cyc();
        check("R4", "saturated", int'(count_o), 255);

        // R8: temperature blocks, empty disarms
        cur_req = "R8";
        drv(0, 1000, 0, 0, 0); cyc();
        drv(0, 400, 0, 0, 0); cyc();
        drv(0, 20, 1, 1, 0); cyc();
        drv(0, 20, 1, 0, 0); cyc();
        drv(0, 1000, 0, 0, 0); cyc();
        drv(0, 20, 1, 0, 4096); cyc();
        drv(0, 20, 1, 0, 10); cyc();
        drv(0, 20, 0, 0, 0); cyc();
        check("R8", "count kept", int'(count_o), 255);

        // R7: intervening charge
        cur_req = "R7";
        drv(0, 1000, 0, 0, 0); cyc();
        drv(0, 700, 0, 0, 0); cyc();
        drv(1, 700, 0, 0, 0); cyc();
        drv(0, 600, 0, 0, 0); cyc();
        drv(0, 10, 1, 0, 0); cyc();
        drv(0, 10, 0, 0, 0); cyc();

        // R6 / R9: qualified learn clears count and flag
        cur_req = "R6";
        drv(0, 1000, 0, 0, 0); cyc();
        drv(1, 1000, 0, 0, 0); cyc();
        drv(0, 500, 0, 0, 0); cyc();
        @(negedge clk);
        drv(0, 10, 1, 0, 4095);
        #0.5;
        check("R6", "learn strobe", int'(learn_ok_o), 1);
        @(posedge clk); #1; model_step();
        cur_req = "R9";
        drv(0, 10, 0, 0, 0); cyc();
        check("R9", "count cleared", int'(count_o), 0);
        check("R9", "inacc cleared", int'(inacc_o), 0);

        // R9: learn wins over simultaneous charge
        for (int i = 0; i < 3; i++) begin
            drv(1, 300, 0, 0, 0); cyc();
        end
        drv(0, 1000, 0, 0, 0); cyc();
        drv(0, 400, 0, 0, 0); cyc();
        drv(1, 10, 1, 0, 0); cyc();
        drv(0, 10, 0, 0, 0); cyc();
        check("R9", "learn beats charge", int'(count_o), 0);

        // R1: reset mid-run
        cur_req = "R1";
        drv(1, 100, 0, 0, 0); cyc();
        rst_n = 1'b0;
        drv(0, 1000, 0, 0, 0);
        @(posedge clk); #1;
        m_cnt = 0; m_ci = 0; m_supp = 0; m_armed = 0;
        rst_n = 1'b1;
        drv(0, 10, 1, 0, 0); cyc();
        drv(0, 10, 0, 0, 0); cyc();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule